// File: doc/BRIEF.md
# Hypercube Store-and-Forward Router Node

This block is one switching node of an n-dimensional binary hypercube. It has one link port for each dimension and one local port through which the attached processor injects and ejects traffic. A packet enters on any port as a header word, followed by payload words. The header gives the destination node and the payload length. The node collects the whole packet in a per-input buffer and checks it. It then answers the sender with an acknowledge or a negative acknowledge. Only after that does it forward the packet.

The output is chosen by deterministic edge-cube routing. The node XORs its own address with the destination address. The lowest set bit of the result names the dimension link to cross next. A zero result means the packet has arrived, and it leaves on the local port. Each output keeps a forwarded packet in the source buffer until the next hop acknowledges it. A negative acknowledge from the next hop makes the output send the packet again from its header. Several buffered packets may want the same output. A round-robin arbiter then hands that output to one of them, and the output stays with that packet until it is released.

Port `p` for `p < DIMS` is the link of dimension `p`. Port `DIMS` is the local port. Words of port `p` occupy bits `[p*W +: W]` of the flat data buses.

Top module: `hc_router`

## Requirements
- R1: When the routing tag `node_addr ^ dest` is nonzero, the packet leaves on the link port whose index is the lowest set bit of the tag.
- R2: When the routing tag is zero, the packet leaves on the local port, index `DIMS`.
- R3: No word of a packet appears on any output before its tail has been accepted and acknowledged. With the output idle, the header appears on the cycle after the acknowledge.
- R4: A header word holds the destination address in bits `[DIMS-1:0]` and the payload word count in bits `[DIMS+LEN_W-1:DIMS]`. Lengths from 1 to `MAX_PAY` are legal. A packet of any legal length, the maximum included, is forwarded whole and in order, header first.
- R5: When the XOR of every bit of every word of a packet, header included, is 0, the input raises `in_ack` for exactly one cycle. That cycle is the one after the tail word is accepted.
- R6: When that XOR is 1, the input raises `in_nak` instead of `in_ack`. The packet is discarded and never forwarded, and the input is ready for a new header.
- R7: A header with length 0 or a length above `MAX_PAY` gets `in_nak` on the next cycle. The next word accepted on that input is treated as a new header.
- R8: `in_ready` of an input stays low from the acceptance of its tail until the downstream side acknowledges the forwarded packet. It is high after reset.
- R9: While `out_valid` is high and `out_ready` is low, the output holds `out_valid` and `out_data` unchanged.
- R10: After sending a tail word, an output sends nothing until `out_ack` or `out_nak`. `out_nak` makes it resend the same packet from the header on the next cycle. `out_ack` frees the source buffer.
- R11: An output serves one packet at a time, from grant to acknowledge. After serving input `g`, it searches for its next grant starting at input `g+1`, wrapping around, so contending inputs are served in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_addr | input | DIMS | Address of this node |
| in_valid | input | DIMS+1 | Word offered on each input port |
| in_data | input | (DIMS+1)*W | Input words, one W-bit slice per port |
| in_ready | output | DIMS+1 | Input port can accept a word |
| in_ack | output | DIMS+1 | One-cycle acknowledge of a good packet |
| in_nak | output | DIMS+1 | One-cycle negative acknowledge |
| out_valid | output | DIMS+1 | Word presented on each output port |
| out_data | output | (DIMS+1)*W | Output words, one W-bit slice per port |
| out_ready | input | DIMS+1 | Next hop accepts the word |
| out_ack | input | DIMS+1 | Next hop acknowledges the packet |
| out_nak | input | DIMS+1 | Next hop rejects the packet; resend it |

## Verification
The bench uses the default build: three dimensions, a 16-bit word and a maximum payload of seven words. That gives four ports, 3-bit addresses and a 4-bit length field, so lengths of 8 to 15 can be written into a header and tested as illegal. With node address 5, every destination reaches a distinct routing tag. The tags include ones with several set bits, so the lowest-bit choice is tested against higher set bits. Four ports also allow three inputs to contend for the local output, which tells round-robin order apart from fixed priority.

// File: rtl/hc_pkg.sv
package hc_pkg;
   typedef enum logic [1:0] {IN_EMPTY, IN_RECV, IN_HELD} in_state_e;
   typedef enum logic [1:0] {OUT_IDLE, OUT_SEND, OUT_WAIT} out_state_e;
endpackage

// File: rtl/hc_in_port.sv
module hc_in_port import hc_pkg::*; #(
   parameter int DIMS    = 3,
   parameter int W       = 16,
   parameter int MAX_PAY = 7,
   parameter int LEN_W   = 4,
   parameter int PIDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIMS-1:0]   node_addr,
   input  logic              in_valid,
   input  logic [W-1:0]      in_data,
   output logic              in_ready,
   output logic              ack,
   output logic              nak,
   output logic              held,
   output logic [PIDX_W-1:0] route,
   output logic [LEN_W-1:0]  plen,
   input  logic [LEN_W-1:0]  rd_idx,
   output logic [W-1:0]      rd_data,
   input  logic              release_pkt
);
   localparam int DEPTH = MAX_PAY + 1;
   localparam int AW    = $clog2(DEPTH);
   localparam logic [LEN_W-1:0] MAXL = LEN_W'(MAX_PAY);

   in_state_e          st;
   logic [W-1:0]       mem [DEPTH];
   logic [LEN_W-1:0]   cnt;
   logic [LEN_W-1:0]   len_q;
   logic [DIMS-1:0]    dst_q;
   logic               par_q;
   logic               acc;
   logic [AW-1:0]      wr_idx;
   logic [LEN_W-1:0]   hdr_len;
   logic [DIMS-1:0]    tag;

   assign in_ready = (st != IN_HELD);
   assign acc      = in_valid && in_ready;
   assign hdr_len  = in_data[DIMS +: LEN_W];
   assign wr_idx   = (st == IN_EMPTY) ? '0 : cnt[AW-1:0];
   assign held     = (st == IN_HELD);
   assign plen     = len_q;
   assign rd_data  = mem[rd_idx[AW-1:0]];
   assign tag      = node_addr ^ dst_q;

   always_comb begin
      route = PIDX_W'(DIMS);
      for (int d = DIMS - 1; d >= 0; d--) begin
         if (tag[d]) route = PIDX_W'(d);
      end
   end

   always_ff @(posedge clk) begin
      if (acc) mem[wr_idx] <= in_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= IN_EMPTY;
         cnt   <= '0;
         len_q <= '0;
         dst_q <= '0;
         par_q <= 1'b0;
         ack   <= 1'b0;
         nak   <= 1'b0;
      end else begin
         ack <= 1'b0;
         nak <= 1'b0;
         case (st)
            IN_EMPTY: if (acc) begin
               dst_q <= in_data[DIMS-1:0];
               len_q <= hdr_len;
               par_q <= ^in_data;
               cnt   <= LEN_W'(1);
               if (hdr_len == '0 || hdr_len > MAXL) nak <= 1'b1;
               else                                 st  <= IN_RECV;
            end
            IN_RECV: if (acc) begin
               cnt   <= cnt + 1'b1;
               par_q <= par_q ^ (^in_data);
               if (cnt == len_q) begin
                  if (par_q ^ (^in_data)) begin
                     nak <= 1'b1;
                     st  <= IN_EMPTY;
                  end else begin
                     ack <= 1'b1;
                     st  <= IN_HELD;
                  end
               end
            end
            IN_HELD: if (release_pkt) st <= IN_EMPTY;
            default: st <= IN_EMPTY;
         endcase
      end
   end

   // R5
   ack_nak_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack && nak));
   // R8
   ack_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> !in_ready);
   // R4
   wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && st == IN_RECV) |-> (cnt <= MAXL));
   // R10
   release_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      release_pkt |-> (st == IN_HELD));
endmodule

// File: rtl/hc_out_port.sv
module hc_out_port import hc_pkg::*; #(
   parameter int NPORT  = 4,
   parameter int W      = 16,
   parameter int LEN_W  = 4,
   parameter int PIDX_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NPORT-1:0]        req,
   input  logic [NPORT*LEN_W-1:0]  in_len_f,
   input  logic [NPORT*W-1:0]      in_dat_f,
   output logic [PIDX_W-1:0]       gnt,
   output logic [LEN_W-1:0]        idx,
   output logic                    busy,
   output logic                    done,
   output logic                    out_valid,
   output logic [W-1:0]            out_data,
   input  logic                    out_ready,
   input  logic                    out_ack,
   input  logic                    out_nak
);
   out_state_e         st;
   logic [PIDX_W-1:0]  ptr;
   logic [PIDX_W-1:0]  pick;
   logic               pick_ok;
   logic [PIDX_W:0]    cand;
   logic [LEN_W-1:0]   sel_len;

   assign sel_len   = in_len_f[gnt*LEN_W +: LEN_W];
   assign out_data  = in_dat_f[gnt*W +: W];
   assign out_valid = (st == OUT_SEND);
   assign busy      = (st != OUT_IDLE);
   assign done      = (st == OUT_WAIT) && out_ack;

   always_comb begin
      pick    = '0;
      pick_ok = 1'b0;
      cand    = '0;
      for (int k = 0; k < NPORT; k++) begin
         cand = {1'b0, ptr} + (PIDX_W+1)'(k);
         if (cand >= (PIDX_W+1)'(NPORT)) cand = cand - (PIDX_W+1)'(NPORT);
         if (!pick_ok && req[cand[PIDX_W-1:0]]) begin
            pick    = cand[PIDX_W-1:0];
            pick_ok = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= OUT_IDLE;
         gnt <= '0;
         idx <= '0;
         ptr <= '0;
      end else begin
         case (st)
            OUT_IDLE: if (pick_ok) begin
               gnt <= pick;
               idx <= '0;
               st  <= OUT_SEND;
            end
            OUT_SEND: if (out_ready) begin
               if (idx == sel_len) st  <= OUT_WAIT;
               else                idx <= idx + 1'b1;
            end
            OUT_WAIT: begin
               if (out_ack) begin
                  st  <= OUT_IDLE;
                  ptr <= (gnt == PIDX_W'(NPORT-1)) ? '0 : gnt + 1'b1;
               end else if (out_nak) begin
                  st  <= OUT_SEND;
                  idx <= '0;
               end
            end
            default: st <= OUT_IDLE;
         endcase
      end
   end

   // R9
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
   // R11
   grant_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> req[gnt]);
endmodule

// File: rtl/hc_router.sv
module hc_router import hc_pkg::*; #(
   parameter int DIMS    = 3,
   parameter int W       = 16,
   parameter int MAX_PAY = 7
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [DIMS-1:0]        node_addr,
   input  logic [DIMS:0]          in_valid,
   input  logic [(DIMS+1)*W-1:0]  in_data,
   output logic [DIMS:0]          in_ready,
   output logic [DIMS:0]          in_ack,
   output logic [DIMS:0]          in_nak,
   output logic [DIMS:0]          out_valid,
   output logic [(DIMS+1)*W-1:0]  out_data,
   input  logic [DIMS:0]          out_ready,
   input  logic [DIMS:0]          out_ack,
   input  logic [DIMS:0]          out_nak
);
   localparam int NPORT  = DIMS + 1;
   localparam int PIDX_W = $clog2(NPORT);
   localparam int LEN_W  = $clog2(MAX_PAY + 2);

   if (DIMS < 1) begin : g_bad_dims
      $error("hc_router: DIMS must be at least 1");
   end
   if (MAX_PAY < 1) begin : g_bad_pay
      $error("hc_router: MAX_PAY must be at least 1");
   end
   if (DIMS + LEN_W > W) begin : g_bad_hdr
      $error("hc_router: header fields do not fit in one word");
   end

   logic [NPORT-1:0]        held;
   logic [NPORT*PIDX_W-1:0] route_f;
   logic [NPORT*LEN_W-1:0]  plen_f;
   logic [NPORT*W-1:0]      rdat_f;
   logic [NPORT*LEN_W-1:0]  oidx_f;
   logic [NPORT*PIDX_W-1:0] ogn_f;
   logic [NPORT-1:0]        obusy;
   logic [NPORT-1:0]        odone;
   logic [NPORT-1:0]        rel;

   for (genvar i = 0; i < NPORT; i++) begin : g_in
      logic [PIDX_W-1:0] rt;
      logic [LEN_W-1:0]  ridx;
      logic [NPORT-1:0]  owners;

      assign rt     = route_f[i*PIDX_W +: PIDX_W];
      assign ridx   = oidx_f[rt*LEN_W +: LEN_W];
      assign rel[i] = odone[rt] && (ogn_f[rt*PIDX_W +: PIDX_W] == PIDX_W'(i));

      hc_in_port #(
         .DIMS(DIMS), .W(W), .MAX_PAY(MAX_PAY), .LEN_W(LEN_W), .PIDX_W(PIDX_W)
      ) u_in (
         .clk        (clk),
         .rst_n      (rst_n),
         .node_addr  (node_addr),
         .in_valid   (in_valid[i]),
         .in_data    (in_data[i*W +: W]),
         .in_ready   (in_ready[i]),
         .ack        (in_ack[i]),
         .nak        (in_nak[i]),
         .held       (held[i]),
         .route      (route_f[i*PIDX_W +: PIDX_W]),
         .plen       (plen_f[i*LEN_W +: LEN_W]),
         .rd_idx     (ridx),
         .rd_data    (rdat_f[i*W +: W]),
         .release_pkt(rel[i])
      );

      always_comb begin
         for (int o = 0; o < NPORT; o++) begin
            owners[o] = obusy[o] && (ogn_f[o*PIDX_W +: PIDX_W] == PIDX_W'(i));
         end
      end

      // R11
      single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(owners) <= 1);
   end

   for (genvar o = 0; o < NPORT; o++) begin : g_out
      logic [NPORT-1:0] req_o;

      always_comb begin
         for (int i = 0; i < NPORT; i++) begin
            req_o[i] = held[i] && (route_f[i*PIDX_W +: PIDX_W] == PIDX_W'(o));
         end
      end

      hc_out_port #(
         .NPORT(NPORT), .W(W), .LEN_W(LEN_W), .PIDX_W(PIDX_W)
      ) u_out (
         .clk       (clk),
         .rst_n     (rst_n),
         .req       (req_o),
         .in_len_f  (plen_f),
         .in_dat_f  (rdat_f),
         .gnt       (ogn_f[o*PIDX_W +: PIDX_W]),
         .idx       (oidx_f[o*LEN_W +: LEN_W]),
         .busy      (obusy[o]),
         .done      (odone[o]),
         .out_valid (out_valid[o]),
         .out_data  (out_data[o*W +: W]),
         .out_ready (out_ready[o]),
         .out_ack   (out_ack[o]),
         .out_nak   (out_nak[o])
      );
   end
endmodule

// File: tb/hc_router_bench.sv
`timescale 1ns/1ps
module hc_router_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [2:0]  node_addr;
   logic [3:0]  in_valid, in_ready, in_ack, in_nak;
   logic [63:0] in_data, out_data;
   logic [3:0]  out_valid, out_ready, out_ack, out_nak;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   logic [15:0] pkt [0:15];

   always #2 clk = ~clk;

   hc_router u_hc_router (
      .clk(clk), .rst_n(rst_n), .node_addr(node_addr),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .in_ack(in_ack), .in_nak(in_nak),
      .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
      .out_ack(out_ack), .out_nak(out_nak)
   );

   // {input port, dest, payload length, expected output port}; node address 3'b101
   localparam logic [10:0] VEC [8] = '{
      {2'd0, 3'b100, 4'd1, 2'd0},
      {2'd1, 3'b111, 4'd2, 2'd1},
      {2'd2, 3'b001, 4'd3, 2'd2},
      {2'd3, 3'b101, 4'd4, 2'd3},
      {2'd0, 3'b010, 4'd5, 2'd0},
      {2'd1, 3'b011, 4'd7, 2'd1},
      {2'd3, 3'b000, 4'd6, 2'd0},
      {2'd0, 3'b001, 4'd2, 2'd2}
   };

   task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   task automatic build(input logic [2:0] dst, input logic [3:0] ln, input logic [4:0] seed);
      logic p;
      pkt[0] = {4'h0, seed, ln, dst};
      for (int k = 1; k < 16; k++) pkt[k] = {seed, 11'(k * 97 + 5)};
      p = 1'b0;
      for (int k = 0; k <= 15; k++) if (k <= int'(ln)) p = p ^ (^pkt[k]);
      if (p) pkt[ln][15] = ~pkt[ln][15];
   endtask

   task automatic do_reset();
      rst_n = 1'b0; in_valid = '0; in_data = '0;
      out_ready = 4'hF; out_ack = '0; out_nak = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic send(input int p, input int n, output logic a, output logic k, output logic early);
      early = 1'b0;
      for (int w = 0; w < n; w++) begin
         in_valid[p] = 1'b1;
         in_data[p*16 +: 16] = pkt[w];
         while (!in_ready[p]) @(negedge clk);
         early = early | (|out_valid);
         @(negedge clk);
      end
      in_valid[p] = 1'b0;
      a = in_ack[p];
      k = in_nak[p];
   endtask

   task automatic recv(input int o, input int n, input int stall, input string rq, output int waited);
      waited = 0;
      while (!out_valid[o] && waited < 30) begin
         @(negedge clk);
         waited++;
      end
      for (int w = 0; w < n; w++) begin
         if (w == stall) begin
            out_ready[o] = 1'b0;
            @(negedge clk);
            @(negedge clk);
            chk(out_valid[o] && out_data[o*16 +: 16] == pkt[w], "R9 hold under stall",
                {out_valid[o], out_data[o*16 +: 16]}, {1'b1, pkt[w]});
            out_ready[o] = 1'b1;
         end
         chk(out_valid[o] && out_data[o*16 +: 16] == pkt[w], rq,
             {out_valid[o], out_data[o*16 +: 16]}, {1'b1, pkt[w]});
         @(negedge clk);
      end
      chk(!out_valid[o], "R10 silent after tail", out_valid[o], 0);
   endtask

   task automatic give_ack(input int o);
      out_ack[o] = 1'b1;
      @(negedge clk);
      out_ack[o] = 1'b0;
   endtask

   task automatic give_nak(input int o);
      out_nak[o] = 1'b1;
      @(negedge clk);
      out_nak[o] = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=hung expected=done");
         summary();
      end
   end

   initial begin
      logic a, k, e;
      int wt;
      node_addr = 3'b101;
      do_reset();
      chk(in_ready == 4'hF, "R8 ready after reset", in_ready, 4'hF);
      chk(out_valid == 4'h0, "R3 no output after reset", out_valid, 0);
      chk((in_ack | in_nak) == 4'h0, "R5 no ack after reset", in_ack | in_nak, 0);

      for (int v = 0; v < 8; v++) begin
         int ip, eo;
         logic [2:0] ds;
         logic [3:0] ln;
         ip = int'(VEC[v][10:9]); ds = VEC[v][8:6]; ln = VEC[v][5:2]; eo = int'(VEC[v][1:0]);
         build(ds, ln, 5'(v));
         send(ip, int'(ln) + 1, a, k, e);
         chk(a && !k, "R5 ack after good tail", {a, k}, 2'b10);
         chk(!e && out_valid == 0, "R3 nothing forwarded before ack", {e, out_valid}, 0);
         chk(!in_ready[ip], "R8 input blocked while held", in_ready[ip], 0);
         recv(eo, int'(ln) + 1, -1, (eo == 3) ? "R2 local delivery R4" : "R1 link choice R4", wt);
         chk(wt == 1, "R3 header one cycle after ack", wt, 1);
         give_ack(eo);
         chk(in_ready[ip], "R8 input freed by downstream ack", in_ready[ip], 1);
      end

      // R10 replay after nak, R9 stall
      build(3'b111, 4'd3, 5'd20);
      send(2, 4, a, k, e);
      chk(a, "R5 ack", a, 1);
      recv(1, 4, 2, "R4 data with stall", wt);
      for (int c = 0; c < 3; c++) begin
         chk(out_valid[1] == 0, "R10 waits for ack", out_valid[1], 0);
         chk(in_ready[2] == 0, "R8 held until ack", in_ready[2], 0);
         @(negedge clk);
      end
      give_nak(1);
      recv(1, 4, -1, "R10 resend from header", wt);
      chk(wt == 0, "R10 resend on next cycle", wt, 0);
      give_ack(1);
      chk(in_ready[2], "R10 buffer freed by ack", in_ready[2], 1);

      // R6 bad parity
      build(3'b100, 4'd2, 5'd21);
      pkt[1][0] = ~pkt[1][0];
      send(0, 3, a, k, e);
      chk(k && !a, "R6 nak on odd parity", {a, k}, 2'b01);
      chk(in_ready[0], "R6 ready after discard", in_ready[0], 1);
      for (int c = 0; c < 5; c++) begin
         chk(out_valid == 0, "R6 discarded packet not sent", out_valid, 0);
         @(negedge clk);
      end

      // R7 illegal lengths
      build(3'b100, 4'd0, 5'd22);
      send(1, 1, a, k, e);
      chk(k && !a, "R7 nak on zero length", {a, k}, 2'b01);
      chk(in_ready[1], "R7 ready after zero length", in_ready[1], 1);
      build(3'b100, 4'd9, 5'd23);
      send(1, 1, a, k, e);
      chk(k && !a, "R7 nak on oversize length", {a, k}, 2'b01);
      build(3'b100, 4'd2, 5'd24);
      send(1, 3, a, k, e);
      chk(a && !k, "R7 next word is a header", {a, k}, 2'b10);
      recv(0, 3, -1, "R7 packet after bad header", wt);
      give_ack(0);

      // R11 round robin on local port
      do_reset();
      out_ready[3] = 1'b0;
      build(3'b101, 4'd2, 5'd25); send(0, 3, a, k, e);
      build(3'b101, 4'd1, 5'd26); send(1, 2, a, k, e);
      build(3'b101, 4'd3, 5'd27); send(3, 4, a, k, e);
      out_ready[3] = 1'b1;
      build(3'b101, 4'd2, 5'd25);
      recv(3, 3, -1, "R11 first grant input 0", wt);
      out_ready[3] = 1'b0;
      give_ack(3);
      build(3'b101, 4'd2, 5'd28); send(0, 3, a, k, e);
      out_ready[3] = 1'b1;
      build(3'b101, 4'd1, 5'd26);
      recv(3, 2, -1, "R11 next grant input 1", wt);
      give_ack(3);
      build(3'b101, 4'd3, 5'd27);
      recv(3, 4, -1, "R11 search from input 2 picks input 3", wt);
      give_ack(3);
      build(3'b101, 4'd2, 5'd28);
      recv(3, 3, -1, "R11 wrap to input 0", wt);
      give_ack(3);
      chk(in_ready == 4'hF, "R11 all inputs free", in_ready, 4'hF);

      finished = 1'b1;
      summary();
   end
endmodule